// File: doc/BRIEF.md
# Split-Bus Converter Word Reassembler

This block rebuilds full conversion words from a converter that sends each 14-bit sample over a narrow 8-bit bus in two halves within a single clock period. The upper 8 bits of a sample are placed on the bus after the falling edge of the clock and are stable at the next rising edge. The lower 6 bits follow after that rising edge and are stable at the next falling edge. The block captures both halves and joins them. It then presents the complete word, registered, in the rising-edge clock domain.

The converter has a fixed pipeline delay, so the first words that come out after start-up hold no real pixel data. A two-bit latency-mode input sets how many words are discarded while the pipeline fills. Modes `00` and `11` discard 8 words, and modes `01` and `10` discard 6. Every word that passes is flagged valid and tagged with a pixel index. The index counts source samples from zero and wraps at the width of the index port. A change of the mode input restarts the fill and the index, so a new line or a new configuration begins at pixel zero.

Top module: `adc_split_reassembler`

## Requirements
- R1: While reset is low, and after it is released until the first combined word, `word_valid` is 0, `pix_idx` is 0 and `word_out` is 0.
- R2: `word_out[13:6]` equals bus bits [7:0] as sampled at a rising clock edge (the high part, driven after the preceding falling edge).
- R3: `word_out[5:0]` equals bus bits [5:0] as sampled at the falling edge after that rising edge. Bus bits [7:6] are ignored in that phase and never reach the output.
- R4: A sample whose high part is captured at rising edge k appears on `word_out` just after rising edge k+1. From the second rising edge after reset on, `word_out` is updated after every rising edge.
- R5: After a reset or a restart, the first L combined words have `word_valid` = 0 and every later word has `word_valid` = 1. L is 8 for `lat_mode` 00 or 11 and 6 for `lat_mode` 01 or 10.
- R6: `pix_idx` is 0 on the first valid word after a reset or restart, and it increases by one on each later valid word.
- R7: `pix_idx` wraps from its all-ones value to 0, counting modulo 2^IDX_W.
- R8: When `lat_mode` at a rising edge differs from its value at the previous rising edge, the word produced at that edge is not valid. The fill count and the pixel index restart, and the new mode's L applies from the next word on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; high part sampled on the rising edge, low part on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Shared data bus carrying the high part, then the low part in bits [5:0] |
| lat_mode | input | 2 | Pipeline-latency mode: 00/11 long fill, 01/10 short fill |
| word_out | output | 14 | Reassembled conversion word |
| word_valid | output | 1 | High for each word that belongs to a real source sample |
| pix_idx | output | IDX_W (default 12) | Source-sample index of the current valid word |

## Verification
On every cycle, the assertions check four things. Each output word must equal the two halves held in the capture registers on the cycle before. The pixel index must step by exactly one between back-to-back valid words, and it must start at zero when valid rises. No valid word may follow a mode change. Only the bench's scenarios can show the rest. One part is the exact number of words discarded in each latency mode, including the restart when switching between two modes with the same latency. The other parts are the wrap of a narrowed index and the fact that junk on the upper bus bits in the low phase has no effect, shown against a long run of varied and extreme sample values.

// File: rtl/adcr_pkg.sv
`timescale 1ns/1ps
package adcr_pkg;

   // Fill length chosen by the two-bit latency mode: odd parity selects the short fill.
   function automatic int unsigned fill_len(input logic [1:0] mode,
                                            input int unsigned long_len,
                                            input int unsigned short_len);
      return (mode[1] ^ mode[0]) ? short_len : long_len;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcr_edge_capture.sv
`timescale 1ns/1ps
module adcr_edge_capture #(
   parameter int BUS_W = 8,
   parameter int HI_W  = 8,
   parameter int LO_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] bus_in,
   output logic [HI_W-1:0]  hi_q,
   output logic [LO_W-1:0]  lo_q,
   output logic             hi_seen
);

   logic [HI_W-1:0] hi_slice;
   logic [LO_W-1:0] lo_slice;

   // High phase: the part sits in the low-order bus lanes; spare lanes are dropped.
   generate
      if (HI_W == BUS_W) begin : g_hi_full
         assign hi_slice = bus_in;
      end else begin : g_hi_part
         logic unused_hi_spare;
         assign hi_slice        = bus_in[HI_W-1:0];
         assign unused_hi_spare = ^bus_in[BUS_W-1:HI_W];
      end
   endgenerate

   // Low phase: only the lowest LO_W lanes carry data.
   generate
      if (LO_W == BUS_W) begin : g_lo_full
         assign lo_slice = bus_in;
      end else begin : g_lo_part
         logic unused_lo_spare;
         assign lo_slice        = bus_in[LO_W-1:0];
         assign unused_lo_spare = ^bus_in[BUS_W-1:LO_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         hi_seen <= 1'b0;
      end else begin
         hi_q    <= hi_slice;
         hi_seen <= 1'b1;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else begin
         lo_q <= lo_slice;
      end
   end

endmodule

// File: rtl/adcr_word_pack.sv
`timescale 1ns/1ps
module adcr_word_pack #(
   parameter int HI_W = 8,
   parameter int LO_W = 6,
   localparam int WORD_W = HI_W + LO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_ready,
   input  logic [HI_W-1:0]   hi_in,
   input  logic [LO_W-1:0]   lo_in,
   output logic [WORD_W-1:0] word_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (pair_ready) begin
         word_q <= {hi_in, lo_in};
      end
   end

endmodule

// File: rtl/adcr_fill_track.sv
`timescale 1ns/1ps
module adcr_fill_track
   import adcr_pkg::*;
#(
   parameter int IDX_W     = 12,
   parameter int LAT_LONG  = 8,
   parameter int LAT_SHORT = 6,
   localparam int LAT_MAX  = int'(max2(LAT_LONG, LAT_SHORT)),
   localparam int CNT_W    = $clog2(LAT_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pair_ready,
   input  logic [1:0]       lat_mode,
   output logic             valid_q,
   output logic [IDX_W-1:0] pix_q
);

   logic [1:0]       mode_q;
   logic [CNT_W-1:0] fill_q;
   logic [CNT_W-1:0] fill_lim;
   logic [IDX_W-1:0] pix_next_q;
   logic             mode_moved;

   assign mode_moved = (lat_mode != mode_q);
   assign fill_lim   = CNT_W'(fill_len(mode_q, LAT_LONG, LAT_SHORT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= 2'b00;
         fill_q     <= '0;
         valid_q    <= 1'b0;
         pix_q      <= '0;
         pix_next_q <= '0;
      end else if (mode_moved) begin
         mode_q     <= lat_mode;
         fill_q     <= '0;
         valid_q    <= 1'b0;
         pix_q      <= '0;
         pix_next_q <= '0;
      end else if (pair_ready) begin
         if (fill_q < fill_lim) begin
            fill_q  <= fill_q + 1'b1;
            valid_q <= 1'b0;
         end else begin
            valid_q    <= 1'b1;
            pix_q      <= pix_next_q;
            pix_next_q <= pix_next_q + 1'b1;
         end
      end else begin
         valid_q <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_split_reassembler.sv
`timescale 1ns/1ps
module adc_split_reassembler #(
   parameter int BUS_W     = 8,
   parameter int HI_W      = 8,
   parameter int LO_W      = 6,
   parameter int LAT_LONG  = 8,
   parameter int LAT_SHORT = 6,
   parameter int IDX_W     = 12,
   localparam int WORD_W   = HI_W + LO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_W-1:0]  bus_in,
   input  logic [1:0]        lat_mode,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid,
   output logic [IDX_W-1:0]  pix_idx
);

   generate
      if (HI_W < 1 || HI_W > BUS_W) begin : g_bad_hi
         $error("HI_W must lie in 1..BUS_W");
      end
      if (LO_W < 1 || LO_W > BUS_W) begin : g_bad_lo
         $error("LO_W must lie in 1..BUS_W");
      end
      if (LAT_LONG < 1 || LAT_SHORT < 1) begin : g_bad_lat
         $error("latency fills must be at least one word");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be positive");
      end
   endgenerate

   logic [HI_W-1:0] cap_hi;
   logic [LO_W-1:0] cap_lo;
   logic            hi_seen;

   adcr_edge_capture #(
      .BUS_W (BUS_W),
      .HI_W  (HI_W),
      .LO_W  (LO_W)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_in  (bus_in),
      .hi_q    (cap_hi),
      .lo_q    (cap_lo),
      .hi_seen (hi_seen)
   );

   adcr_word_pack #(
      .HI_W (HI_W),
      .LO_W (LO_W)
   ) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_ready (hi_seen),
      .hi_in      (cap_hi),
      .lo_in      (cap_lo),
      .word_q     (word_out)
   );

   adcr_fill_track #(
      .IDX_W     (IDX_W),
      .LAT_LONG  (LAT_LONG),
      .LAT_SHORT (LAT_SHORT)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_ready (hi_seen),
      .lat_mode   (lat_mode),
      .valid_q    (word_valid),
      .pix_q      (pix_idx)
   );

endmodule

// File: rtl/adcr_reasm_chk.sv
`timescale 1ns/1ps
module adcr_reasm_chk #(
   parameter int HI_W  = 8,
   parameter int LO_W  = 6,
   parameter int IDX_W = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           lat_mode,
   input logic [HI_W+LO_W-1:0] word_out,
   input logic                 word_valid,
   input logic [IDX_W-1:0]     pix_idx,
   input logic [HI_W-1:0]      cap_hi,
   input logic [LO_W-1:0]      cap_lo,
   input logic                 hi_seen
);

   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2, R3, R4: the word is the pair of halves held one edge earlier
   p_pair_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(hi_seen)) |-> (word_out == $past({cap_hi, cap_lo})));

   // R6: consecutive valid words carry consecutive indices
   p_pix_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && word_valid && $past(word_valid)) |-> (pix_idx == $past(pix_idx) + 1'b1));

   // R6: a run of valid words starts at index zero
   p_pix_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $rose(word_valid)) |-> (pix_idx == '0));

   // R8: a mode change is followed by an invalid word
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (lat_mode != $past(lat_mode))) |=> !word_valid);

endmodule

bind adc_split_reassembler adcr_reasm_chk #(
   .HI_W  (HI_W),
   .LO_W  (LO_W),
   .IDX_W (IDX_W)
) u_reasm_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lat_mode   (lat_mode),
   .word_out   (word_out),
   .word_valid (word_valid),
   .pix_idx    (pix_idx),
   .cap_hi     (cap_hi),
   .cap_lo     (cap_lo),
   .hi_seen    (hi_seen)
);

// File: tb/adc_split_reassembler_bench.sv
`timescale 1ns/1ps
module adc_split_reassembler_bench;

   localparam int IDX_W  = 4;
   localparam int LAST_K = 120;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  bus_in;
   logic [1:0]  lat_mode;
   logic [13:0] word_out;
   logic        word_valid;
   logic [IDX_W-1:0] pix_idx;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   adc_split_reassembler #(.IDX_W(IDX_W)) u_adc_split_reassembler (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_in     (bus_in),
      .lat_mode   (lat_mode),
      .word_out   (word_out),
      .word_valid (word_valid),
      .pix_idx    (pix_idx)
   );

   function automatic logic [13:0] sample_val(input int k);
      if (k % 7 == 3)       return 14'h3FFF;
      else if (k % 11 == 5) return 14'h0000;
      else                  return 14'((k * 679 + 435) & 16'h3FFF);
   endfunction

   function automatic int lat_for(input logic [1:0] m);
      return (m == 2'b01 || m == 2'b10) ? 6 : 8;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   initial begin
      #5ms;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      int cur_lat;
      rst_n    = 1'b0;
      bus_in   = 8'h00;
      lat_mode = 2'b00;
      repeat (3) @(posedge clk);
      #5;
      check("R1 reset valid", 32'(word_valid), 32'd0);
      check("R1 reset pix",   32'(pix_idx),    32'd0);
      check("R1 reset word",  32'(word_out),   32'd0);
      base    = 0;
      cur_lat = lat_for(2'b00);
      for (int k = 0; k <= LAST_K; k++) begin
         logic [13:0] v;
         bit          moved;
         logic [1:0]  new_mode;
         v = sample_val(k);
         @(negedge clk);
         #2;
         if (k == 0) rst_n = 1'b1;
         bus_in = v[13:6];
         @(posedge clk);
         #2;
         // low phase with junk on bits [7:6]
         bus_in = {2'(k) ^ 2'b10, v[5:0]};
         moved    = 1'b0;
         new_mode = lat_mode;
         if (k == 40)      begin new_mode = 2'b01; moved = 1'b1; end
         else if (k == 70) begin new_mode = 2'b10; moved = 1'b1; end
         else if (k == 92) begin new_mode = 2'b11; moved = 1'b1; end
         lat_mode = new_mode;
         #3;
         if (k == 0) begin
            check("R1 first edge valid", 32'(word_valid), 32'd0);
            check("R1 first edge word",  32'(word_out),   32'd0);
         end else begin
            logic [13:0] pv;
            pv = sample_val(k - 1);
            check("R4 word timing", 32'(word_out),       32'(pv));
            check("R2 high part",   32'(word_out[13:6]), 32'(pv[13:6]));
            check("R3 low part",    32'(word_out[5:0]),  32'(pv[5:0]));
            if (k == base) begin
               check("R8 restart word invalid", 32'(word_valid), 32'd0);
            end else begin
               int r;
               r = k - base - 1;
               check("R5 fill gating", 32'(word_valid), (r >= cur_lat) ? 32'd1 : 32'd0);
               if (r >= cur_lat) begin
                  if (r - cur_lat >= (1 << IDX_W))
                     check("R7 index wrap", 32'(pix_idx), 32'((r - cur_lat) % (1 << IDX_W)));
                  else
                     check("R6 index count", 32'(pix_idx), 32'(r - cur_lat));
               end
            end
         end
         if (moved) begin
            base    = k + 1;
            cur_lat = lat_for(new_mode);
         end
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule